// File: doc/BRIEF.md
# Host-DSP Mailbox Exchange Registers

This block holds the two 16-bit words through which a host processor and a DSP core hand work to each other. The first is a shared exchange word that either side may write and read. The second is a status word whose two low bits act as sticky handshake flags. Each flag is raised by a write on one side and dropped when the other side reads the status. The DSP can also store the whole status word directly.

The host reaches the block through a four-slot word window with a chip-select, a write strobe and a word offset. The exchange word appears twice in that window, so the host may use either slot. The DSP reaches the block through a single-cycle strobe with a register index. A claim input lets a programmed-memory-access unit take over DSP accesses to the status index; while it is asserted, the block neither stores, returns nor clears the status on that access. All read data is combinational from the current register contents. Writes and flag changes take effect at the next clock edge.

Top module: `mbx_xchg_regs`

## Requirements
- R1: After reset, the exchange word and the status word are both zero.
- R2: Host word offsets 0 and 1 both address the exchange word. A host write through either slot stores the host data, and a host read of either slot returns the exchange word.
- R3: A host read at offset 2 returns the status word. A host read at offset 3 returns zero. Host writes at offsets 2 and 3 change neither register.
- R4: A DSP write to index 11 (exchange word) stores the DSP data and sets status bit 0 at the next edge.
- R5: A host read at offset 2 clears status bit 0 at the next edge. The read itself returns the value from before the clear.
- R6: A host write to the exchange word through offset 0 or offset 1 sets status bit 1 at the next edge.
- R7: An unclaimed DSP read of index 8 (status) returns the status word and clears bit 1 at the next edge. The returned value is the one from before the clear.
- R8: An unclaimed DSP write to index 8 stores all 16 bits of the DSP data into the status word. When the claim input is high, a DSP access to index 8 leaves the status unchanged, and a read returns zero.
- R9: When a flag is set and cleared in the same cycle, it ends up set. A set also overrides a DSP store to the status in the same cycle.
- R10: When both sides write the exchange word in the same cycle, the host data is kept (default priority).
- R11: A DSP read of an index other than 8 or 11 returns zero. A DSP read of index 11 returns the exchange word with no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host chip-select; a read when host_we is low |
| host_we | input | 1 | Host write strobe |
| host_off | input | 2 | Host word offset within the window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| dsp_stb | input | 1 | DSP single-cycle access strobe |
| dsp_we | input | 1 | DSP access is a write |
| dsp_idx | input | 4 | DSP register index |
| dsp_claim | input | 1 | Status-index access taken by the memory-access unit |
| dsp_wdata | input | 16 | DSP write data |
| dsp_rdata | output | 16 | DSP read data (combinational) |

## Verification
The hardest situations to reach are those where both ports hit the same flag or the same word in one cycle. Examples are a host status read that clears bit 0 while the DSP writes the exchange word, and a DSP status store that lands while a host write sets bit 1. A long sweep of independent host and DSP operations reaches these cases, because every operation, index and offset is drawn on both ports in every cycle, including claimed accesses. Directed sequences then force each collision explicitly and read the result back through both ports. Every read is compared against an arithmetic model that tracks the side effects of the reads themselves.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned FLAG_DSP_WROTE  = 0;
   localparam int unsigned FLAG_HOST_WROTE = 1;
   localparam int unsigned NUM_FLAGS       = 2;

   typedef enum logic [1:0] {
      SLOT_XCHG_A = 2'd0,
      SLOT_XCHG_B = 2'd1,
      SLOT_STATUS = 2'd2,
      SLOT_EMPTY  = 2'd3
   } host_slot_e;
endpackage

// File: rtl/mbx_host_port.sv
module mbx_host_port
   import mbx_pkg::*;
#(
   parameter int unsigned DW     = 16,
   parameter int unsigned HOFF_W = 2
) (
   input  logic              cs,
   input  logic              we,
   input  logic [HOFF_W-1:0] off,
   input  logic [DW-1:0]     xchg_q,
   input  logic [DW-1:0]     stat_q,
   output logic              xchg_wr,
   output logic              stat_rd,
   output logic [DW-1:0]     rdata
);
   host_slot_e slot;
   logic       upper_zero;

   generate
      if (HOFF_W > 2) begin : g_wide
         assign upper_zero = (off[HOFF_W-1:2] == '0);
      end else begin : g_narrow
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      slot = upper_zero ? host_slot_e'(off[1:0]) : SLOT_EMPTY;
   end

   always_comb begin
      xchg_wr = cs && we && ((slot == SLOT_XCHG_A) || (slot == SLOT_XCHG_B));
      stat_rd = cs && !we && (slot == SLOT_STATUS);
   end

   always_comb begin
      rdata = '0;
      unique case (slot)
         SLOT_XCHG_A, SLOT_XCHG_B: rdata = xchg_q;
         SLOT_STATUS:              rdata = stat_q;
         default:                  rdata = '0;
      endcase
   end
endmodule

// File: rtl/mbx_dsp_port.sv
module mbx_dsp_port #(
   parameter int unsigned DW       = 16,
   parameter int unsigned IDX_W    = 4,
   parameter int unsigned IDX_STAT = 8,
   parameter int unsigned IDX_XCHG = 11
) (
   input  logic             stb,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic             claim,
   input  logic [DW-1:0]    xchg_q,
   input  logic [DW-1:0]    stat_q,
   output logic             xchg_wr,
   output logic             stat_wr,
   output logic             stat_rd,
   output logic [DW-1:0]    rdata
);
   localparam logic [IDX_W-1:0] SEL_STAT = IDX_W'(IDX_STAT);
   localparam logic [IDX_W-1:0] SEL_XCHG = IDX_W'(IDX_XCHG);

   logic hit_stat, hit_xchg, raw_stat;

   always_comb begin
      hit_stat = (idx == SEL_STAT);
      hit_xchg = (idx == SEL_XCHG);
      raw_stat = hit_stat && !claim;
      xchg_wr  = stb && we && hit_xchg;
      stat_wr  = stb && we && raw_stat;
      stat_rd  = stb && !we && raw_stat;
   end

   always_comb begin
      if (hit_xchg)      rdata = xchg_q;
      else if (raw_stat) rdata = stat_q;
      else               rdata = '0;
   end
endmodule

// File: rtl/mbx_status_reg.sv
module mbx_status_reg
   import mbx_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DW-1:0]        load_val,
   input  logic [NUM_FLAGS-1:0] set,
   input  logic [NUM_FLAGS-1:0] clr,
   output logic [DW-1:0]        q
);
   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (b < NUM_FLAGS) begin : g_flag
         logic nxt;
         always_comb begin
            nxt = load ? load_val[b] : q[b];
            if (clr[b]) nxt = 1'b0;
            if (set[b]) nxt = 1'b1;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[b] <= 1'b0;
            else        q[b] <= nxt;
         end
         AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set[b] |=> q[b]); // R9
         AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr[b] && !set[b]) |=> !q[b]); // R5
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q[b] <= 1'b0;
            else if (load) q[b] <= load_val[b];
         end
      end
   end

   AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!load && set == '0 && clr == '0) |=> $stable(q)); // R3
   AST_STAT_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n) load |=> q[DW-1:NUM_FLAGS] == $past(load_val[DW-1:NUM_FLAGS])); // R8
endmodule

// File: rtl/mbx_xchg_reg.sv
module mbx_xchg_reg #(
   parameter int unsigned DW        = 16,
   parameter bit          HOST_WINS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic [DW-1:0] host_d,
   input  logic          dsp_wr,
   input  logic [DW-1:0] dsp_d,
   output logic [DW-1:0] q
);
   logic          any_wr;
   logic [DW-1:0] win_d;

   generate
      if (HOST_WINS) begin : g_host_first
         assign win_d = host_wr ? host_d : dsp_d;
         AST_HOST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n) host_wr |=> q == $past(host_d)); // R10
      end else begin : g_dsp_first
         assign win_d = dsp_wr ? dsp_d : host_d;
         AST_DSP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n) dsp_wr |=> q == $past(dsp_d)); // R10
      end
   endgenerate

   assign any_wr = host_wr || dsp_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (any_wr) q <= win_d;
   end

   AST_XCHG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !any_wr |=> $stable(q)); // R2
endmodule

// File: rtl/mbx_xchg_regs.sv
module mbx_xchg_regs
   import mbx_pkg::*;
#(
   parameter int unsigned DW        = 16,
   parameter int unsigned HOFF_W    = 2,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned IDX_STAT  = 8,
   parameter int unsigned IDX_XCHG  = 11,
   parameter bit          HOST_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs,
   input  logic              host_we,
   input  logic [HOFF_W-1:0] host_off,
   input  logic [DW-1:0]     host_wdata,
   output logic [DW-1:0]     host_rdata,
   input  logic              dsp_stb,
   input  logic              dsp_we,
   input  logic [IDX_W-1:0]  dsp_idx,
   input  logic              dsp_claim,
   input  logic [DW-1:0]     dsp_wdata,
   output logic [DW-1:0]     dsp_rdata
);
   initial begin
      assert (DW >= NUM_FLAGS) else $error("DW must hold both flags");
      assert (HOFF_W >= 2) else $error("host window needs four slots");
      assert (IDX_STAT < (1 << IDX_W) && IDX_XCHG < (1 << IDX_W)) else $error("index out of range");
      assert (IDX_STAT != IDX_XCHG) else $error("indices must differ");
   end

   logic [DW-1:0] xchg_q, stat_q;
   logic          h_xchg_wr, h_stat_rd;
   logic          d_xchg_wr, d_stat_wr, d_stat_rd;
   logic [NUM_FLAGS-1:0] flag_set, flag_clr;

   mbx_host_port #(.DW(DW), .HOFF_W(HOFF_W)) u_host (
      .cs(host_cs), .we(host_we), .off(host_off),
      .xchg_q(xchg_q), .stat_q(stat_q),
      .xchg_wr(h_xchg_wr), .stat_rd(h_stat_rd), .rdata(host_rdata)
   );

   mbx_dsp_port #(.DW(DW), .IDX_W(IDX_W), .IDX_STAT(IDX_STAT), .IDX_XCHG(IDX_XCHG)) u_dsp (
      .stb(dsp_stb), .we(dsp_we), .idx(dsp_idx), .claim(dsp_claim),
      .xchg_q(xchg_q), .stat_q(stat_q),
      .xchg_wr(d_xchg_wr), .stat_wr(d_stat_wr), .stat_rd(d_stat_rd), .rdata(dsp_rdata)
   );

   always_comb begin
      flag_set = '0;
      flag_clr = '0;
      flag_set[FLAG_DSP_WROTE]  = d_xchg_wr;
      flag_set[FLAG_HOST_WROTE] = h_xchg_wr;
      flag_clr[FLAG_DSP_WROTE]  = h_stat_rd;
      flag_clr[FLAG_HOST_WROTE] = d_stat_rd;
   end

   mbx_xchg_reg #(.DW(DW), .HOST_WINS(HOST_WINS)) u_xchg (
      .clk(clk), .rst_n(rst_n),
      .host_wr(h_xchg_wr), .host_d(host_wdata),
      .dsp_wr(d_xchg_wr), .dsp_d(dsp_wdata), .q(xchg_q)
   );

   mbx_status_reg #(.DW(DW)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .load(d_stat_wr), .load_val(dsp_wdata),
      .set(flag_set), .clr(flag_clr), .q(stat_q)
   );

   AST_DSP_SETS_B0: assert property (@(posedge clk) disable iff (!rst_n) (dsp_stb && dsp_we && dsp_idx == IDX_W'(IDX_XCHG)) |=> stat_q[0]); // R4
   AST_HOST_SETS_B1: assert property (@(posedge clk) disable iff (!rst_n) (host_cs && host_we && host_off[HOFF_W-1:1] == '0) |=> stat_q[1]); // R6
   AST_DSP_RD_CLR_B1: assert property (@(posedge clk) disable iff (!rst_n) (dsp_stb && !dsp_we && !dsp_claim && dsp_idx == IDX_W'(IDX_STAT) && !(host_cs && host_we && host_off[HOFF_W-1:1] == '0)) |=> !stat_q[1]); // R7
   AST_HOST_RD_CLR_B0: assert property (@(posedge clk) disable iff (!rst_n) (host_cs && !host_we && host_off == HOFF_W'(2) && !(dsp_stb && dsp_we && dsp_idx == IDX_W'(IDX_XCHG))) |=> !stat_q[0]); // R5
endmodule

// File: tb/tb_mbx_xchg_regs.sv
module tb_mbx_xchg_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_cs = 0, host_we = 0;
   logic [1:0]  host_off = 0;
   logic [15:0] host_wdata = 0, host_rdata;
   logic        dsp_stb = 0, dsp_we = 0, dsp_claim = 0;
   logic [3:0]  dsp_idx = 0;
   logic [15:0] dsp_wdata = 0, dsp_rdata;

   int n_chk = 0, n_bad = 0;
   logic [15:0] m_x = 0, m_s = 0;
   bit done = 0;

   always #2 clk = ~clk;

   mbx_xchg_regs dut (
      .clk(clk), .rst_n(rst_n),
      .host_cs(host_cs), .host_we(host_we), .host_off(host_off),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .dsp_stb(dsp_stb), .dsp_we(dsp_we), .dsp_idx(dsp_idx), .dsp_claim(dsp_claim),
      .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %04h expected %04h", tag, act, exp);
      end
   endtask

   // one cycle with both ports driven; reads compared mid-cycle, model stepped after the edge
   task automatic step(input bit hcs, input bit hwe, input logic [1:0] hoff, input logic [15:0] hwd,
                       input bit dstb, input bit dwe, input logic [3:0] didx, input bit dcl,
                       input logic [15:0] dwd);
      logic [15:0] nx, ns;
      @(negedge clk);
      host_cs = hcs; host_we = hwe; host_off = hoff; host_wdata = hwd;
      dsp_stb = dstb; dsp_we = dwe; dsp_idx = didx; dsp_claim = dcl; dsp_wdata = dwd;
      #1;
      if (hcs && !hwe) begin
         case (hoff)
            2'd0, 2'd1: chk("R2 host exchange read", host_rdata, m_x);
            2'd2:       chk("R5 host status read", host_rdata, m_s);
            default:    chk("R3 host empty slot", host_rdata, 16'h0);
         endcase
      end
      if (dstb && !dwe) begin
         if (didx == 4'd11)              chk("R11 dsp exchange read", dsp_rdata, m_x);
         else if (didx == 4'd8 && !dcl)  chk("R7 dsp status read", dsp_rdata, m_s);
         else if (didx == 4'd8)          chk("R8 claimed status read", dsp_rdata, 16'h0);
         else                            chk("R11 dsp unmapped read", dsp_rdata, 16'h0);
      end
      nx = m_x; ns = m_s;
      if (dstb && dwe && didx == 4'd8 && !dcl) ns = dwd;
      if (hcs && !hwe && hoff == 2'd2) ns[0] = 1'b0;
      if (dstb && !dwe && didx == 4'd8 && !dcl) ns[1] = 1'b0;
      if (dstb && dwe && didx == 4'd11) begin nx = dwd; ns[0] = 1'b1; end
      if (hcs && hwe && hoff <= 2'd1) begin nx = hwd; ns[1] = 1'b1; end
      @(posedge clk);
      #1;
      host_cs = 0; dsp_stb = 0;
      m_x = nx; m_s = ns;
   endtask

   task automatic idle(); step(0,0,0,0, 0,0,0,0,0); endtask
   task automatic h_wr(input logic [1:0] o, input logic [15:0] d); step(1,1,o,d, 0,0,0,0,0); endtask
   task automatic h_rd(input logic [1:0] o); step(1,0,o,0, 0,0,0,0,0); endtask
   task automatic d_wr(input logic [3:0] i, input bit c, input logic [15:0] d); step(0,0,0,0, 1,1,i,c,d); endtask
   task automatic d_rd(input logic [3:0] i, input bit c); step(0,0,0,0, 1,0,i,c,0); endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state through both ports
      chk("R1 host exchange after reset", host_rdata, 16'h0);
      rst_n = 1'b1;
      d_rd(4'd11, 0);
      h_rd(2'd2);
      d_rd(4'd8, 0);
      chk("R1 status zero", dsp_rdata, 16'h0);

      // R2 both aliases, R6 flag from each
      h_wr(2'd0, 16'hA5C3); d_rd(4'd11, 0);
      d_rd(4'd8, 0);                 // R6 sees 0002, then clears (R7)
      d_rd(4'd8, 0);                 // R7 bit 1 gone
      h_wr(2'd1, 16'h1234); h_rd(2'd0); h_rd(2'd1);
      d_rd(4'd8, 0);

      // R3 writes to offsets 2 and 3 have no effect
      h_wr(2'd2, 16'hFFFF); h_wr(2'd3, 16'hFFFF);
      h_rd(2'd2); h_rd(2'd3); h_rd(2'd0);

      // R4 / R5: DSP write sets bit 0, host status read returns then clears
      d_wr(4'd11, 0, 16'h0F0F); h_rd(2'd2); h_rd(2'd2); h_rd(2'd1);

      // R8 store, claim blocks store, read and clear
      d_wr(4'd8, 0, 16'hBEE0); h_rd(2'd2);
      d_wr(4'd8, 1, 16'h0000); h_wr(2'd0, 16'h0001);
      d_rd(4'd8, 1); h_rd(2'd2);
      d_rd(4'd8, 0); d_rd(4'd8, 0);

      // R9 set wins over clear and over store, both flags
      step(1,0,2'd2,0, 1,1,4'd11,0,16'h7777); h_rd(2'd2);
      step(1,1,2'd1,16'h4242, 1,0,4'd8,0,0);  d_rd(4'd8, 0);
      step(1,1,2'd0,16'h9999, 1,1,4'd8,0,16'h8000); h_rd(2'd2);

      // R10 coincident exchange writes
      step(1,1,2'd0,16'hCAFE, 1,1,4'd11,0,16'hDEAD); d_rd(4'd11, 0); h_rd(2'd2);

      // R11 every DSP index
      for (int i = 0; i < 16; i++) d_rd(4'(i), 0);

      // sweep of independent host and DSP operations
      for (int n = 0; n < 6000; n++) begin
         int unsigned r = $urandom();
         int unsigned w = $urandom();
         step(r[0], r[1], r[3:2], w[15:0], r[4], r[5],
              r[6] ? (r[7] ? 4'd8 : 4'd11) : r[11:8], r[12] & r[13], w[31:16]);
         if (r[20:17] == 0) idle();
      end
      h_rd(2'd2); d_rd(4'd8, 0); d_rd(4'd11, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule